// File: doc/BRIEF.md
# I2C Master Serial-Clock Generator

This block produces the serial-clock waveform that an I2C master drives onto the bus. It works from the peripheral clock and a programmed divider word. Standard mode gives a symmetric clock. Fast mode gives one of two low:high ratios, chosen by a duty-select bit. The output is an open-drain style pull-low enable. The pad logic turns it into a low drive, or releases the line so the pull-up can raise it.

The block counts the high half of each period only while the sampled bus line actually reads high. A slave that holds the clock low, or a second master that drives it, therefore lengthens the period instead of being overridden. The low half is a pure count. Two single-cycle strobes mark the observed rising and falling edges of the line, so the data path can shift and sample in step with the real bus. Spike filtering and slope control belong elsewhere.

Top module: `scl_clock_gen`

## Requirements
- R1: While reset is asserted or the enable is low, the pull-low output is 0. The line is never driven.
- R2: In Standard mode (mode bit 0) with a divider value D of 4 or more, the line is pulled low for D clock cycles, then released for D cycles of observed-high line, and this repeats.
- R3: In Standard mode a divider value below 4 is treated as 4.
- R4: In Fast mode (mode bit 1) with duty bit 0, the low phase lasts 2·D cycles and the high phase lasts D observed-high cycles.
- R5: In Fast mode with duty bit 1, the low phase lasts 16·D cycles and the high phase lasts 9·D observed-high cycles.
- R6: In Fast mode a divider value of 0 is treated as 1.
- R7: During the high phase the counter advances only in cycles where the sampled line is 1. Holding the line low for S extra cycles after release lengthens the released interval by exactly S cycles. The following low phase keeps its programmed length.
- R8: The rising strobe is 1 for exactly one cycle: the first cycle in which the sampled line reads 1 after reading 0. The falling strobe is 1 for exactly one cycle: the first cycle in which the line reads 0 after 1. The two are never 1 together.
- R9: The strobes follow the sampled line, not the driven value. An external low pulse while the block is disabled produces a fall strobe and then a rise strobe, while the pull-low output stays 0.
- R10: Dropping the enable releases the line in the same cycle. Re-enabling starts a fresh low phase of full length.
- R11: The first phase after the enable rises is the low phase, and the pull-low output is 1 from the first enabled cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Clock generation enable |
| fast_mode | input | 1 | 0 = Standard mode, 1 = Fast mode |
| duty_sel | input | 1 | Fast-mode ratio: 0 = 2:1, 1 = 16:9 (low:high) |
| ccr | input | CCR_W | Divider value D |
| scl_in | input | 1 | Sampled, already synchronised bus clock line |
| scl_pull_low | output | 1 | 1 = drive the line low, 0 = release |
| scl_rise | output | 1 | One-cycle strobe on an observed rising edge |
| scl_fall | output | 1 | One-cycle strobe on an observed falling edge |

## Verification
The phase-length assertions assume that the mode bit, the duty bit and the divider are held constant while the enable is high. They also assume that the sampled line never reads high while the block pulls it low. The bench changes the configuration only while the enable is low. It models the line as the wired-AND of the block's release and an external holder. The holder is used for stretch cases and for disabled-state pulses.

// File: rtl/scl_gen_pkg.sv
// Package: shared phase type and minimum divider limits for the serial-clock generator.
// Assumes: nothing; pure declarations.
package scl_gen_pkg;

    typedef enum logic [0:0] {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } scl_phase_e;

    localparam int unsigned STD_MIN_DIV  = 4;
    localparam int unsigned FAST_MIN_DIV = 1;

endpackage

// File: rtl/scl_phase_calc.sv
// Module: scl_phase_calc
// Turns mode, duty bit and divider into the low and high phase lengths in clock cycles.
// It clamps the divider to the legal minimum of each mode.
// Assumes: configuration is static while the generator is enabled.
module scl_phase_calc
    import scl_gen_pkg::*;
#(
    parameter int unsigned CCR_W = 12,
    parameter int unsigned CNT_W = CCR_W + 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fast_mode,
    input  logic             duty_sel,
    input  logic [CCR_W-1:0] ccr,
    output logic [CNT_W-1:0] low_len,
    output logic [CNT_W-1:0] high_len
);

    localparam logic [CCR_W-1:0] STD_MIN  = CCR_W'(STD_MIN_DIV);
    localparam logic [CCR_W-1:0] FAST_MIN = CCR_W'(FAST_MIN_DIV);

    logic [CCR_W-1:0] div_min;
    logic [CNT_W-1:0] div_c;

    // Pick the minimum for the mode and clamp the divider to it.
    always_comb begin
        div_min = fast_mode ? FAST_MIN : STD_MIN;
        div_c   = (ccr < div_min) ? CNT_W'(div_min) : CNT_W'(ccr);
    end

    // Scale the clamped divider into phase lengths using shifts and adds.
    always_comb begin
        if (!fast_mode) begin
            low_len  = div_c;
            high_len = div_c;
        end else if (!duty_sel) begin
            low_len  = div_c << 1;
            high_len = div_c;
        end else begin
            low_len  = div_c << 4;
            high_len = (div_c << 3) + div_c;
        end
    end

    // R6
    high_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        high_len != '0);

    // R4
    low_not_shorter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        low_len >= high_len);

endmodule

// File: rtl/scl_line_edges.sv
// Module: scl_line_edges
// Gives one-cycle rise and fall strobes from the sampled bus clock line.
// Assumes: scl_in is already synchronised to clk. The idle bus reads high.
module scl_line_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    output logic scl_rise,
    output logic scl_fall
);

    logic scl_q;

    // Keep the previous sample of the line; idle-high after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) scl_q <= 1'b1;
        else        scl_q <= scl_in;
    end

    // Compare the current sample with the previous one to find edges.
    always_comb begin
        scl_rise = scl_in & ~scl_q;
        scl_fall = ~scl_in & scl_q;
    end

    // R8
    rise_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scl_rise |=> !scl_rise);

    // R8
    fall_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scl_fall |=> !scl_fall);

    // R8
    edges_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(scl_rise && scl_fall));

endmodule

// File: rtl/scl_clock_gen.sv
// Module: scl_clock_gen (top)
// Master serial-clock generator. It counts the low phase and drives the line low.
// It then releases the line and counts the high phase only in cycles where the line reads high.
// Assumes: configuration is static while en is high, and scl_in is synchronised.
module scl_clock_gen
    import scl_gen_pkg::*;
#(
    parameter int unsigned CCR_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             fast_mode,
    input  logic             duty_sel,
    input  logic [CCR_W-1:0] ccr,
    input  logic             scl_in,
    output logic             scl_pull_low,
    output logic             scl_rise,
    output logic             scl_fall
);

    localparam int unsigned CNT_W = CCR_W + 5;

    logic [CNT_W-1:0] low_len;
    logic [CNT_W-1:0] high_len;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_inc;
    scl_phase_e       ph;

    scl_phase_calc #(
        .CCR_W (CCR_W),
        .CNT_W (CNT_W)
    ) u_calc (
        .clk       (clk),
        .rst_n     (rst_n),
        .fast_mode (fast_mode),
        .duty_sel  (duty_sel),
        .ccr       (ccr),
        .low_len   (low_len),
        .high_len  (high_len)
    );

    scl_line_edges u_edges (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_in),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall)
    );

    // Next count value, shared by both phases.
    always_comb cnt_inc = cnt + 1'b1;

    // Phase sequencer: a fixed low count, then a high count gated by the observed line.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            ph  <= PH_LOW;
            cnt <= '0;
        end else begin
            case (ph)
                PH_LOW: begin
                    if (cnt_inc >= low_len) begin
                        ph  <= PH_HIGH;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt_inc;
                    end
                end
                default: begin
                    if (scl_in) begin
                        if (cnt_inc >= high_len) begin
                            ph  <= PH_LOW;
                            cnt <= '0;
                        end else begin
                            cnt <= cnt_inc;
                        end
                    end
                end
            endcase
        end
    end

    // Drive low only while enabled, out of reset, and in the low phase.
    always_comb scl_pull_low = rst_n && en && (ph == PH_LOW);

    // R10
    disabled_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cnt == '0 && ph == PH_LOW));

    // R7
    stretch_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && ph == PH_HIGH && !scl_in) |=> (cnt == $past(cnt) && ph == PH_HIGH));

    // R2
    low_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && ph == PH_LOW) |-> (cnt < low_len));

    // R7
    high_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && ph == PH_HIGH) |-> (cnt < high_len));

endmodule

// File: tb/scl_clock_gen_test.sv
module scl_clock_gen_test;

    localparam int CCR_W = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             en = 1'b0;
    logic             fast_mode = 1'b0;
    logic             duty_sel = 1'b0;
    logic [CCR_W-1:0] ccr = '0;
    logic             ext_low = 1'b0;
    logic             scl_in;
    logic             scl_pull_low;
    logic             scl_rise;
    logic             scl_fall;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    // Wired-AND bus: released by the block and not held by the external device.
    assign scl_in = !scl_pull_low && !ext_low;

    scl_clock_gen #(.CCR_W(CCR_W)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .en           (en),
        .fast_mode    (fast_mode),
        .duty_sel     (duty_sel),
        .ccr          (ccr),
        .scl_in       (scl_in),
        .scl_pull_low (scl_pull_low),
        .scl_rise     (scl_rise),
        .scl_fall     (scl_fall)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    // Run one period for a configuration, with S stretch cycles; check the phase lengths and strobes.
    task automatic run_cfg(input logic fm, input logic dt, input int c, input int s,
                           input string req);
        int d, lo_e, hi_e, n, rises, falls, first_rise;
        d = fm ? ((c < 1) ? 1 : c) : ((c < 4) ? 4 : c);
        if (!fm)      begin lo_e = d;      hi_e = d;     end
        else if (!dt) begin lo_e = 2 * d;  hi_e = d;     end
        else          begin lo_e = 16 * d; hi_e = 9 * d; end
        @(negedge clk); en = 1'b0; fast_mode = fm; duty_sel = dt; ccr = CCR_W'(c); ext_low = 1'b0;
        @(negedge clk); en = 1'b1; #1;
        rises = 0; falls = 0;
        // R11 first enabled cycle pulls low; fall strobe in that cycle.
        check({req, " R11 first-phase-low"}, int'(scl_pull_low), 1);
        n = 0;
        while (scl_pull_low && n < 2000) begin
            rises += int'(scl_rise); falls += int'(scl_fall);
            n++; @(negedge clk); #1;
        end
        check({req, " low-length"}, n, lo_e);
        n = 0; first_rise = -1;
        while (!scl_pull_low && n < 2000) begin
            ext_low = (n < s);
            #0.1;
            if (scl_rise && first_rise < 0) first_rise = n;
            rises += int'(scl_rise); falls += int'(scl_fall);
            n++; @(negedge clk); #1;
        end
        ext_low = 1'b0;
        // R7 released interval equals high length plus stretch.
        check({req, " R7 high-length"}, n, hi_e + s);
        check({req, " R8 rise-position"}, first_rise, s);
        check({req, " R8 rise-count"}, rises, 1);
        check({req, " R8 fall-count"}, falls, 1);
        n = 0;
        while (scl_pull_low && n < 2000) begin n++; @(negedge clk); #1; end
        check({req, " second-low-length"}, n, lo_e);
        // R10 drop enable mid-phase: released at once.
        repeat (1) @(negedge clk);
        en = 1'b0; #1;
        check({req, " R10 release"}, int'(scl_pull_low), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state
        check("R1 reset-release", int'(scl_pull_low), 0);
        en = 1'b1; #1;
        check("R1 reset-with-en", int'(scl_pull_low), 0);
        en = 1'b0;
        @(negedge clk); rst_n = 1'b1; #1;
        check("R1 disabled-release", int'(scl_pull_low), 0);

        // R2 and R3: Standard-mode sweep, including clamped values.
        for (int c = 0; c <= 8; c++) run_cfg(1'b0, 1'b0, c, 0, (c < 4) ? "R3" : "R2");
        // R4 and R6: Fast mode, duty 0.
        for (int c = 0; c <= 6; c++) run_cfg(1'b1, 1'b0, c, 0, (c == 0) ? "R6" : "R4");
        // R5: Fast mode, duty 1.
        for (int c = 0; c <= 3; c++) run_cfg(1'b1, 1'b1, c, 0, (c == 0) ? "R6" : "R5");
        // R7: stretching.
        run_cfg(1'b0, 1'b0, 5, 1, "R7");
        run_cfg(1'b0, 1'b0, 5, 3, "R7");
        run_cfg(1'b0, 1'b0, 6, 7, "R7");
        run_cfg(1'b1, 1'b1, 1, 10, "R7");
        run_cfg(1'b1, 1'b0, 1, 2, "R7");

        // R10: re-enable mid low phase gives a full-length low phase.
        @(negedge clk); fast_mode = 1'b0; ccr = 12'd6; en = 1'b1;
        repeat (3) @(negedge clk);
        en = 1'b0;
        @(negedge clk); en = 1'b1; #1;
        begin
            int n = 0;
            while (scl_pull_low && n < 100) begin n++; @(negedge clk); #1; end
            check("R10 restart-low-length", n, 6);
        end
        @(negedge clk); en = 1'b0;

        // R9: external pulse while disabled gives strobes from the line.
        @(negedge clk); ext_low = 1'b1; #1;
        check("R9 fall-from-line", int'(scl_fall), 1);
        check("R9 no-drive", int'(scl_pull_low), 0);
        @(negedge clk); #1;
        check("R9 fall-one-cycle", int'(scl_fall), 0);
        ext_low = 1'b0; #1;
        check("R9 rise-from-line", int'(scl_rise), 1);
        @(negedge clk); #1;
        check("R9 rise-one-cycle", int'(scl_rise), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule